// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave side of a three-wire control link. Through it a host microcontroller reads and writes a bank of 32 eight-bit registers. The three wires are a frame enable, a shift clock and one data line that both ends drive in turn. The block does not own the registers. It presents an address, a write strobe with write data, and a read strobe to the register bank. It takes the addressed register's contents back on a read-data input.

All three serial inputs are brought into the system clock domain through synchronizer flops. Edges of the shift clock are detected there, and the whole frame engine runs on the system clock with a synchronous active-high reset. The data line is split into an input, an output and an output enable, so that the pad's tristate buffer stays at the chip edge.

A frame has three parts in this order: a direction bit, five address bits, and eight data bits. On a write, the host shifts all fourteen bits in and the block commits the data to the bank. On a read, the block fetches the register once the address is complete. It then turns the line around and shifts the register contents out.

Top module: `tri_wire_regport`

## Requirements
- R1: After reset, `sdio_oe`, `wr_stb` and `rd_stb` are all low.
- R2: Input bits are taken on rising edges of `sclk` while `frame_en` is high. Bit 1 is the direction: 1 means read and 0 means write. Bits 2 to 6 are the address, most significant bit first. Bits 7 to 14 are the data, most significant bit first.
- R3: On a write frame, after the 14th rising edge the block raises `wr_stb` for exactly one system clock cycle. In that cycle `reg_addr` holds the 5-bit address and `wr_data` holds the 8 data bits.
- R4: On a read frame, `rd_data` for `reg_addr` is captured after the last address bit. Starting at the falling edge that follows the 6th rising edge, `sdio_oe` is high and `sdio_out` carries the captured byte, most significant bit first. Each bit changes on a falling edge and is valid before the next rising edge.
- R5: `sdio_oe` stays low for the whole of a write frame, and during the direction and address bits of a read frame.
- R6: On a read frame, after the 14th rising edge the block raises `rd_stb` for exactly one cycle with the frame's address on `reg_addr`. `wr_stb` and `rd_stb` are never high together.
- R7: Dropping `frame_en` resets the frame and releases `sdio_oe`. A frame cut short before its 14th rising edge produces no strobe and leaves the bank unchanged.
- R8: Rising edges after the 14th are ignored. There is no second strobe, the written data is unchanged, and `sdio_oe` goes low at the falling edge after the 14th rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_en | input | 1 | Frame enable from host, high during an access |
| sclk | input | 1 | Shift clock from host |
| sdio_in | input | 1 | Data line as seen at the pad input |
| sdio_out | output | 1 | Data bit to drive onto the line |
| sdio_oe | output | 1 | Output enable for the data line pad |
| reg_addr | output | 5 | Register address of the current frame |
| wr_stb | output | 1 | One-cycle write strobe to the register bank |
| wr_data | output | 8 | Write data to the register bank |
| rd_data | input | 8 | Contents of the register at `reg_addr` |
| rd_stb | output | 1 | One-cycle strobe after a completed read |

## Verification
The bench targets the line turnaround. A design that enabled its driver one bit early would fight the host on the last address bit. One that enabled it late would hand the host a stale first data bit. Both would show up as address-phase drive or as a wrong read byte. Frames cut short after a partial data phase check that a premature commit is caught as a wrong read-back of an untouched register. Runs of extra shift-clock pulses after bit 14 expose a counter that wraps and fires a second strobe. Address extremes 0 and 31 and the data patterns 00, FF and A5 catch bit-order and shift-direction mistakes.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    // Total rising edges in one frame: direction + address + data
    function automatic int frame_len(input int aw, input int dw);
        return 1 + aw + dw;
    endfunction

endpackage

// File: rtl/twr_sync.sv
module twr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic en_o,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    logic [STAGES-1:0] en_q, sclk_q, sdi_q;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            sclk_q    <= '0;
            sdi_q     <= '0;
            sclk_prev <= 1'b0;
        end else begin
            en_q      <= {en_q[STAGES-2:0], en_i};
            sclk_q    <= {sclk_q[STAGES-2:0], sclk_i};
            sdi_q     <= {sdi_q[STAGES-2:0], sdi_i};
            sclk_prev <= sclk_q[STAGES-1];
        end
    end

    assign en_o   = en_q[STAGES-1];
    assign sdi_o  = sdi_q[STAGES-1];
    assign rise_o = sclk_q[STAGES-1] & ~sclk_prev;
    assign fall_o = ~sclk_q[STAGES-1] & sclk_prev;
endmodule

// File: rtl/twr_frame.sv
module twr_frame
    import twr_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = 14,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              rise,
    input  logic              sdi,
    output logic [CNT_W-1:0]  cnt,
    output logic              dir_rd,
    output logic              fetch,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data,
    output logic              wr_stb,
    output logic              rd_stb
);
    localparam logic [CNT_W-1:0] LAST_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] DONE      = CNT_W'(FRAME_BITS);

    dir_e dir;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir    <= DIR_WR;
            fetch  <= 1'b0;
            addr   <= '0;
            data   <= '0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
        end else if (!en) begin
            cnt    <= '0;
            dir    <= DIR_WR;
            fetch  <= 1'b0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
        end else begin
            fetch  <= 1'b0;
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (rise && cnt != DONE) begin
                cnt <= cnt + 1'b1;
                if (cnt == '0)
                    dir <= dir_e'(sdi);
                else if (cnt <= LAST_ADDR)
                    addr <= {addr[ADDR_W-2:0], sdi};
                else if (dir == DIR_WR)
                    data <= {data[DATA_W-2:0], sdi};
                if (cnt == LAST_ADDR && dir == DIR_RD)
                    fetch <= 1'b1;
                if (cnt == LAST_BIT) begin
                    wr_stb <= (dir == DIR_WR);
                    rd_stb <= (dir == DIR_RD);
                end
            end
        end
    end

    assign dir_rd = (dir == DIR_RD);
endmodule

// File: rtl/twr_txdrv.sv
module twr_txdrv #(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter int FRAME_BITS = 14,
    parameter int CNT_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              fall,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dir_rd,
    input  logic              fetch,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              oe
);
    localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(ADDR_W + 1);
    localparam logic [CNT_W-1:0] DONE       = CNT_W'(FRAME_BITS);

    logic [DATA_W-1:0] tx, src;

    // A fetch and a falling edge may land in the same cycle
    assign src = fetch ? rd_data : tx;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            tx  <= '0;
            sdo <= 1'b0;
            oe  <= 1'b0;
        end else begin
            tx <= src;
            if (fall && dir_rd) begin
                if (cnt >= FIRST_DATA && cnt < DONE) begin
                    oe  <= 1'b1;
                    sdo <= src[DATA_W-1];
                    tx  <= {src[DATA_W-2:0], 1'b0};
                end else if (cnt == DONE) begin
                    oe <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/tri_wire_regport.sv
module tri_wire_regport
    import twr_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_en,
    input  logic              sclk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_stb
);
    localparam int FRAME_BITS = frame_len(ADDR_W, DATA_W);
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic             en_s, rise, fall, sdi_s, dir_rd, fetch;
    logic [CNT_W-1:0] cnt;

    twr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .en_i(frame_en), .sclk_i(sclk), .sdi_i(sdio_in),
        .en_o(en_s), .rise_o(rise), .fall_o(fall), .sdi_o(sdi_s)
    );

    twr_frame #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
    ) u_frame (
        .clk(clk), .rst(rst), .en(en_s), .rise(rise), .sdi(sdi_s),
        .cnt(cnt), .dir_rd(dir_rd), .fetch(fetch),
        .addr(reg_addr), .data(wr_data),
        .wr_stb(wr_stb), .rd_stb(rd_stb)
    );

    twr_txdrv #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
    ) u_tx (
        .clk(clk), .rst(rst), .en(en_s), .fall(fall),
        .cnt(cnt), .dir_rd(dir_rd), .fetch(fetch), .rd_data(rd_data),
        .sdo(sdio_out), .oe(sdio_oe)
    );
endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
    parameter int ADDR_W     = 5,
    parameter int FRAME_BITS = 14,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             en_s,
    input logic [CNT_W-1:0] cnt,
    input logic             dir_rd,
    input logic             sdio_oe,
    input logic             wr_stb,
    input logic             rd_stb
);
    a_r3_wr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    a_r6_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);

    a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb));

    a_r5_oe_read_only: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> dir_rd);

    a_r4_oe_turn_on: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> cnt == CNT_W'(ADDR_W + 1));

    a_r8_strobe_full_frame: assert property (@(posedge clk) disable iff (rst)
        (wr_stb || rd_stb) |-> cnt == CNT_W'(FRAME_BITS));

    a_r7_release_on_disable: assert property (@(posedge clk) disable iff (rst)
        !en_s |=> (!sdio_oe && !wr_stb && !rd_stb));
endmodule

bind tri_wire_regport twr_checker #(
    .ADDR_W(ADDR_W), .FRAME_BITS(FRAME_BITS), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst(rst), .en_s(en_s), .cnt(cnt), .dir_rd(dir_rd),
    .sdio_oe(sdio_oe), .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/tri_wire_regport_bench.sv
`timescale 1ns/1ps
module tri_wire_regport_bench;
    localparam int H = 8;  // system clocks per shift-clock half period

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_en = 1'b0, sclk = 1'b0, sdio_in = 1'b0;
    logic       sdio_out, sdio_oe, wr_stb, rd_stb;
    logic [4:0] reg_addr;
    logic [7:0] wr_data, rd_data;

    logic [7:0] bank [32];
    logic [7:0] exp_bank [32];
    int checks = 0, failures = 0;
    int wr_cnt = 0, rd_cnt = 0;
    logic [4:0] last_wa, last_ra;
    logic [7:0] last_wd;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    tri_wire_regport u_tri_wire_regport (
        .clk(clk), .rst(rst), .frame_en(frame_en), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .reg_addr(reg_addr), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_data(rd_data), .rd_stb(rd_stb)
    );

    assign rd_data = bank[reg_addr];

    always @(posedge clk) begin
        if (wr_stb) begin
            bank[wr_data === wr_data ? reg_addr : 5'd0] <= wr_data;
            wr_cnt <= wr_cnt + 1;
            last_wa <= reg_addr;
            last_wd <= wr_data;
        end
        if (rd_stb) begin
            rd_cnt <= rd_cnt + 1;
            last_ra <= reg_addr;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One host access with a chosen number of rising edges
    task automatic do_frame(input bit rd, input logic [4:0] a, input logic [7:0] d,
                            input int edges, output logic [7:0] got,
                            output int bad_addr_oe, output int bad_data_oe);
        logic [13:0] bits;
        bits = {rd, a, d};
        got = '0;
        bad_addr_oe = 0;
        bad_data_oe = 0;
        @(negedge clk);
        frame_en = 1'b1;
        wait_clk(H);
        for (int k = 0; k < edges; k++) begin
            sclk = 1'b0;
            sdio_in = (k < 14 && !(rd && k >= 6)) ? bits[13-k] : 1'b0;
            wait_clk(H);
            if (k < 14) begin
                if (rd && k >= 6) begin
                    got = {got[6:0], sdio_out};
                    if (!sdio_oe) bad_data_oe++;
                end else if (sdio_oe) begin
                    bad_addr_oe++;
                end
            end
            sclk = 1'b1;
            wait_clk(H);
        end
        sclk = 1'b0;
        wait_clk(2*H);
        frame_en = 1'b0;
        sdio_in = 1'b0;
        wait_clk(2*H);
    endtask

    task automatic t_reset();
        chk(sdio_oe == 1'b0, "R1 oe after reset", int'(sdio_oe), 0);
        chk(wr_stb == 1'b0 && rd_stb == 1'b0, "R1 strobes after reset",
            int'({wr_stb, rd_stb}), 0);
    endtask

    task automatic t_write_read(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] got;
        int ba, bd, w0, r0;
        w0 = wr_cnt;
        do_frame(1'b0, a, d, 14, got, ba, bd);
        exp_bank[a] = d;
        chk(wr_cnt == w0 + 1, "R3 one write strobe", wr_cnt - w0, 1);
        chk(last_wa == a && last_wd == d, "R3 R2 write addr/data",
            int'({last_wa, last_wd}), int'({a, d}));
        chk(ba == 0, "R5 no drive during write", ba, 0);
        r0 = rd_cnt;
        do_frame(1'b1, a, 8'h00, 14, got, ba, bd);
        chk(got == exp_bank[a], "R4 R2 read data", int'(got), int'(exp_bank[a]));
        chk(bd == 0, "R4 oe during read data", bd, 0);
        chk(ba == 0, "R5 no drive in read address phase", ba, 0);
        chk(rd_cnt == r0 + 1 && last_ra == a, "R6 read strobe and addr",
            int'(last_ra), int'(a));
        chk(sdio_oe == 1'b0, "R7 released after frame", int'(sdio_oe), 0);
    endtask

    task automatic t_abort();
        logic [7:0] got;
        int ba, bd, w0, r0;
        w0 = wr_cnt;
        do_frame(1'b0, 5'd7, 8'h99, 10, got, ba, bd);
        chk(wr_cnt == w0, "R7 short write no strobe", wr_cnt - w0, 0);
        w0 = wr_cnt;
        do_frame(1'b0, 5'd7, 8'h66, 13, got, ba, bd);
        chk(wr_cnt == w0, "R7 write cut at 13 no strobe", wr_cnt - w0, 0);
        r0 = rd_cnt;
        do_frame(1'b1, 5'd7, 8'h00, 9, got, ba, bd);
        chk(rd_cnt == r0, "R7 short read no strobe", rd_cnt - r0, 0);
        chk(sdio_oe == 1'b0, "R7 oe released after abort", int'(sdio_oe), 0);
        do_frame(1'b1, 5'd7, 8'h00, 14, got, ba, bd);
        chk(got == exp_bank[7], "R7 bank untouched by short write",
            int'(got), int'(exp_bank[7]));
    endtask

    task automatic t_extra();
        logic [7:0] got;
        int ba, bd, w0, r0;
        w0 = wr_cnt;
        do_frame(1'b0, 5'd19, 8'hC3, 19, got, ba, bd);
        exp_bank[19] = 8'hC3;
        chk(wr_cnt == w0 + 1, "R8 single write with extra clocks", wr_cnt - w0, 1);
        chk(last_wd == 8'hC3, "R8 extra clocks keep data", int'(last_wd), 'hC3);
        r0 = rd_cnt;
        do_frame(1'b1, 5'd19, 8'h00, 19, got, ba, bd);
        chk(rd_cnt == r0 + 1, "R8 single read with extra clocks", rd_cnt - r0, 1);
        chk(got == 8'hC3, "R8 read data with extra clocks", int'(got), 'hC3);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            bank[i] = 8'(i * 7 + 3);
            exp_bank[i] = 8'(i * 7 + 3);
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        t_reset();
        t_write_read(5'd0, 8'hA5);
        t_write_read(5'd31, 8'hFF);
        t_write_read(5'd18, 8'h00);
        t_write_read(5'd11, 8'h3C);
        t_abort();
        t_extra();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule